// File: doc/BRIEF.md
# Oversampled Nine-Bit Serial Receiver

This block recovers eleven-bit asynchronous frames from a single serial line. A frame is a low start bit, eight data bits sent least significant first, a ninth data bit, and a stop bit. An external rate generator supplies a one-cycle tick at sixteen times the bit rate. The receiver splits every bit period into sixteen slices with a slice counter, and it decides each bit from three samples taken near the centre of the bit.

The line passes through a two-flop synchronizer. The receiver then watches it on every tick for a high-to-low step. When it sees one, it zeroes its slice counter so that later bit centres are measured from that edge. If the start bit decides high, the receiver treats the edge as noise and goes back to waiting. When a frame completes, the byte and the ninth bit are loaded, and a sticky done flag is raised. This happens only if the flag is clear and the address-filter rule passes. Otherwise the frame is dropped and the earlier contents stay in place. Software clears the flag with a one-cycle strobe.

Top module: `ovs_frame_rx`

## Requirements
- R1: While `rxEnable` is low the receiver is held idle. A frame sent entirely while it is low, or one during which it drops, loads nothing: `rxDone`, `rxByte` and `rxNinth` keep their previous values.
- R2: On a tick where the synchronized line is low and was high on the previous tick, an idle, enabled receiver starts a frame and resets its slice counter to 0. A frame whose start edge falls at any phase of the tick sequence is decoded correctly.
- R3: Each bit is the 2-of-3 majority of the synchronized line sampled on the ticks where the slice count is 8, 9 and 10. A disturbance that corrupts only one of these samples does not change the bit. One that corrupts two of them does change it.
- R4: If the start bit decides high, the frame is abandoned and nothing is loaded. The receiver then accepts the next falling edge as a new start.
- R5: Data bits arrive least significant first into `rxByte[0]` through `rxByte[7]`. The bit after them appears on `rxNinth`.
- R6: A completed frame is loaded only if `rxDone` is 0. A frame that completes while `rxDone` is 1 is discarded and the held byte and ninth bit are kept.
- R7: With `addrFilter` high, a frame whose stop bit decides 0 is discarded. With `addrFilter` low it is loaded. A frame with a stop bit of 1 is loaded under either setting.
- R8: `rxDone` rises in the cycle after a load and stays high until a cycle in which `flagClear` is high. That clear takes effect at the next clock edge.
- R9: Once the stop bit has been decided at slice count 10, the receiver is idle. A start edge that arrives in the second half of the stop bit period begins a new frame.
- R10: After reset, `rxDone` is 0 and `rxByte` and `rxNinth` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idles high |
| rxEnable | input | 1 | Reception allowed while high |
| addrFilter | input | 1 | When high, frames with a low stop bit are rejected |
| flagClear | input | 1 | One-cycle strobe that clears `rxDone` |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxByte | output | 8 | Last accepted data byte |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| rxDone | output | 1 | Sticky flag: a frame has been accepted |

## Verification
The bench places short glitches at exact clock offsets inside a bit. One glitch corrupts a single vote sample and another corrupts two. A receiver that sampled one point or the wrong slices would flip the first case, and one that did not vote would miss the second. A short low pulse on the line checks that a false start is abandoned and that the receiver recovers in time to take the next frame. Without that, the pulse would be shifted in as a garbage byte.

Frames are also sent in these conditions:
- with a stop bit cut off just after its centre, followed at once by a new frame;
- while the done flag is still set;
- with the filter on and a low stop bit;
- with reception disabled partway through a frame.

A receiver that waited out the whole stop bit would lose the back-to-back frame. One that ignored the flag, the filter or the enable would overwrite the held byte.

// File: rtl/ovsrx_pkg.sv
package ovsrx_pkg;

  typedef enum logic [0:0] {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rxState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic takeA;    // capture first vote sample
    logic takeB;    // capture second vote sample
    logic shiftBit; // shift decided data bit into assembly register
    logic loadOut;  // transfer assembled frame to outputs and set flag
  } rxStrobe_t;

endpackage

// File: rtl/ovsrx_ctrl.sv
module ovsrx_ctrl
  import ovsrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS_RATE    = 16,
  parameter int VOTE_CENTER = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      addrFilter,
  input  logic      tick16,
  input  logic      fallSeen,
  input  logic      voteBit,
  input  logic      doneFlag,
  output rxStrobe_t stb
);

  localparam int CNT_W      = $clog2(OVS_RATE);
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] SLICE_A    = CNT_W'(VOTE_CENTER - 1);
  localparam logic [CNT_W-1:0] SLICE_B    = CNT_W'(VOTE_CENTER);
  localparam logic [CNT_W-1:0] SLICE_DEC  = CNT_W'(VOTE_CENTER + 1);
  localparam logic [CNT_W-1:0] SLICE_LAST = CNT_W'(OVS_RATE - 1);
  localparam logic [IDX_W-1:0] IDX_STOP   = IDX_W'(FRAME_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] sliceCnt;
  logic [IDX_W-1:0] bitIdx;

  logic activeTick, decide, atStart, atStop, falseStart, endFrame;

  always_comb begin
    activeTick = tick16 && rxEnable && (state == RX_ACTIVE);
    decide     = activeTick && (sliceCnt == SLICE_DEC);
    atStart    = (bitIdx == '0);
    atStop     = (bitIdx == IDX_STOP);
    falseStart = decide && atStart && voteBit;
    endFrame   = decide && atStop;

    stb          = '0;
    stb.takeA    = activeTick && (sliceCnt == SLICE_A);
    stb.takeB    = activeTick && (sliceCnt == SLICE_B);
    stb.shiftBit = decide && !atStart && !atStop;
    stb.loadOut  = endFrame && !doneFlag && (!addrFilter || voteBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      sliceCnt <= '0;
      bitIdx   <= '0;
    end else if (!rxEnable) begin
      state    <= RX_IDLE;
      sliceCnt <= '0;
      bitIdx   <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (tick16 && fallSeen) begin
            state    <= RX_ACTIVE;
            sliceCnt <= '0;
            bitIdx   <= '0;
          end
        end
        RX_ACTIVE: begin
          if (tick16) begin
            sliceCnt <= sliceCnt + 1'b1;
            if (sliceCnt == SLICE_LAST) bitIdx <= bitIdx + 1'b1;
            if (falseStart || endFrame) begin
              state    <= RX_IDLE;
              sliceCnt <= '0;
              bitIdx   <= '0;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R1: disabled receiver is idle on the following cycle
  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == RX_IDLE));

  // R2: a detected edge realigns the slice counter
  p_edge_realign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && rxEnable && tick16 && fallSeen)
      |=> (state == RX_ACTIVE && sliceCnt == '0 && bitIdx == '0));

  // R4: high start decision returns to idle
  p_false_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decide && atStart && voteBit) |=> (state == RX_IDLE));

  // R9: idle right after the stop-bit decision
  p_stop_mid_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decide && atStop) |=> (state == RX_IDLE));

  // R6: a load is never issued while the flag is set
  p_load_needs_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |-> !doneFlag);

  // R3: at most one strobe in a cycle
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeA, stb.takeB, stb.shiftBit, stb.loadOut}));

endmodule

// File: rtl/ovsrx_dp.sv
module ovsrx_dp
  import ovsrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 tick16,
  input  logic                 flagClear,
  input  rxStrobe_t            stb,
  output logic                 fallSeen,
  output logic                 voteBit,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxNinth,
  output logic                 rxDone
);

  localparam int SHIFT_W = DATA_BITS + 1;

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   lineSync;
  logic                   prevLine;
  logic                   sampA, sampB;
  logic [SHIFT_W-1:0]     assembleReg;
  logic [DATA_BITS-1:0]   byteReg;
  logic                   ninthReg;
  logic                   doneReg;

  generate
    if (SYNC_STAGES > 1) begin : g_multi_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], rxLine};
      end
    end else begin : g_single_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= rxLine;
      end
    end
  endgenerate

  assign lineSync = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevLine <= 1'b1;
    else if (tick16) prevLine <= lineSync;
  end

  assign fallSeen = prevLine && !lineSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else begin
      if (stb.takeA) sampA <= lineSync;
      if (stb.takeB) sampB <= lineSync;
    end
  end

  // third sample is the live line on the deciding tick
  assign voteBit = (sampA & sampB) | (sampA & lineSync) | (sampB & lineSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             assembleReg <= '0;
    else if (stb.shiftBit) assembleReg <= {voteBit, assembleReg[SHIFT_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= '0;
      ninthReg <= 1'b0;
      doneReg  <= 1'b0;
    end else if (stb.loadOut) begin
      byteReg  <= assembleReg[DATA_BITS-1:0];
      ninthReg <= assembleReg[DATA_BITS];
      doneReg  <= 1'b1;
    end else if (flagClear) begin
      doneReg  <= 1'b0;
    end
  end

  assign rxByte  = byteReg;
  assign rxNinth = ninthReg;
  assign rxDone  = doneReg;

  // R6: held outputs change only on a load
  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> ($stable(byteReg) && $stable(ninthReg)));

  // R8: flag rises after a load
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |=> doneReg);

  // R8: flag is sticky without a clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneReg && !flagClear) |=> doneReg);

  // R8: clear strobe drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !stb.loadOut) |=> !doneReg);

endmodule

// File: rtl/ovs_frame_rx.sv
module ovs_frame_rx
  import ovsrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS_RATE    = 16,
  parameter int VOTE_CENTER = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 addrFilter,
  input  logic                 flagClear,
  input  logic                 tick16,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxNinth,
  output logic                 rxDone
);

  rxStrobe_t stb;
  logic      fallSeen;
  logic      voteBit;

  ovsrx_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OVS_RATE   (OVS_RATE),
    .VOTE_CENTER(VOTE_CENTER)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .addrFilter(addrFilter),
    .tick16    (tick16),
    .fallSeen  (fallSeen),
    .voteBit   (voteBit),
    .doneFlag  (rxDone),
    .stb       (stb)
  );

  ovsrx_dp #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .tick16   (tick16),
    .flagClear(flagClear),
    .stb      (stb),
    .fallSeen (fallSeen),
    .voteBit  (voteBit),
    .rxByte   (rxByte),
    .rxNinth  (rxNinth),
    .rxDone   (rxDone)
  );

endmodule

// File: tb/ovs_frame_rx_bench.sv
`timescale 1ns/1ps
module ovs_frame_rx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b0;
  logic       addrFilter = 1'b0;
  logic       tick16 = 1'b0;
  logic       monClear = 1'b0;
  logic       manClear = 1'b0;
  logic       flagClear;
  logic [7:0] rxByte;
  logic       rxNinth;
  logic       rxDone;
  logic [1:0] phase = 2'd0;

  int checks = 0;
  int errors = 0;
  bit autoClear = 1'b1;
  bit finished = 1'b0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  assign flagClear = monClear | manClear;

  always #2.5 clk = ~clk;

  // one tick every four clocks
  always @(negedge clk) begin
    phase  <= phase + 2'd1;
    tick16 <= (phase == 2'd3);
  end

  ovs_frame_rx u_ovs_frame_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .flagClear(flagClear), .tick16(tick16),
    .rxByte(rxByte), .rxNinth(rxNinth), .rxDone(rxDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectFrame(input logic [7:0] d, input logic nin, input string tag);
    expQ.push_back({nin, d});
    tagQ.push_back(tag);
  endtask

  // drives one frame; bit periods are 64 clocks; optional glitch and enable drop
  task automatic sendFrame(input logic [7:0] d, input logic nin, input logic stopVal,
                           input int stopLen, input int waitPhase,
                           input int gBit, input int gLo, input int gHi,
                           input int dropBit);
    logic [10:0] bits;
    bits = {stopVal, nin, d, 1'b0};
    @(negedge clk);
    if (waitPhase >= 0)
      while (phase != waitPhase[1:0]) @(negedge clk);
    for (int b = 0; b < 11; b++) begin
      int len;
      len = (b == 10) ? stopLen : 64;
      for (int t = 0; t < len; t++) begin
        logic v;
        v = bits[b];
        if (b == gBit && t >= gLo && t <= gHi) v = ~v;
        if (b == dropBit && t == 0) rxEnable = 1'b0;
        rxLine = v;
        @(negedge clk);
      end
    end
    rxLine = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    bit doneSeen;
    logic [8:0] exp;
    string tag;
    doneSeen = 1'b0;
    forever begin
      @(negedge clk);
      monClear = 1'b0;
      if (rstN && rxDone && !doneSeen) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R6: actual unexpected load %h expected no load", {rxNinth, rxByte});
        end else begin
          exp = expQ.pop_front();
          tag = tagQ.pop_front();
          if ({rxNinth, rxByte} !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, {rxNinth, rxByte}, exp);
          end
        end
        if (autoClear) monClear = 1'b1;
      end
      doneSeen = rxDone;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R10: reset state
    chk("R10 done", {31'd0, rxDone}, 32'd0);
    chk("R10 byte", {24'd0, rxByte}, 32'd0);
    chk("R10 ninth", {31'd0, rxNinth}, 32'd0);
    rxEnable = 1'b1;
    idle(20);

    // R5: basic frames, LSB first, ninth bit
    expectFrame(8'hA5, 1'b1, "R5 frame A5");
    sendFrame(8'hA5, 1'b1, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(10);
    // R2: start edges at other tick phases
    expectFrame(8'h3C, 1'b0, "R2 phase1");
    sendFrame(8'h3C, 1'b0, 1'b1, 64, 1, -1, 0, 0, -1);
    idle(10);
    expectFrame(8'hC3, 1'b1, "R2 phase2");
    sendFrame(8'hC3, 1'b1, 1'b1, 64, 2, -1, 0, 0, -1);
    idle(10);
    expectFrame(8'h96, 1'b0, "R2 phase3");
    sendFrame(8'h96, 1'b0, 1'b1, 64, 3, -1, 0, 0, -1);
    idle(10);

    // R3: one corrupted sample on d3 is outvoted
    expectFrame(8'h00, 1'b0, "R3 single glitch");
    sendFrame(8'h00, 1'b0, 1'b1, 64, 0, 4, 40, 42, -1);
    idle(10);
    // R3: two corrupted samples on d1 flip it
    expectFrame(8'hFD, 1'b1, "R3 double glitch");
    sendFrame(8'hFF, 1'b1, 1'b1, 64, 0, 2, 40, 46, -1);
    idle(10);

    // R4: short low pulse is a false start
    @(negedge clk);
    rxLine = 1'b0;
    idle(20);
    rxLine = 1'b1;
    idle(100);
    chk("R4 no load after false start", {31'd0, rxDone}, 32'd0);
    chk("R4 byte kept", {24'd0, rxByte}, 32'h0000_00FD);
    expectFrame(8'h5A, 1'b0, "R4 recovery frame");
    sendFrame(8'h5A, 1'b0, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(10);

    // R7: filter rejects low stop bit
    addrFilter = 1'b1;
    sendFrame(8'h13, 1'b1, 1'b0, 64, 0, -1, 0, 0, -1);
    idle(20);
    chk("R7 filtered no flag", {31'd0, rxDone}, 32'd0);
    chk("R7 filtered byte kept", {23'd0, rxNinth, rxByte}, 32'h0000_005A);
    expectFrame(8'h81, 1'b1, "R7 filter stop high");
    sendFrame(8'h81, 1'b1, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(10);
    addrFilter = 1'b0;
    expectFrame(8'h42, 1'b0, "R7 no filter stop low");
    sendFrame(8'h42, 1'b0, 1'b0, 64, 0, -1, 0, 0, -1);
    idle(20);

    // R6 and R8: flag held, second frame discarded
    autoClear = 1'b0;
    expectFrame(8'h11, 1'b1, "R6 first frame");
    sendFrame(8'h11, 1'b1, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(10);
    sendFrame(8'h22, 1'b0, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(10);
    chk("R8 flag sticky", {31'd0, rxDone}, 32'd1);
    chk("R6 byte kept", {23'd0, rxNinth, rxByte}, 32'h0000_0111);
    manClear = 1'b1;
    @(negedge clk);
    manClear = 1'b0;
    chk("R8 flag cleared", {31'd0, rxDone}, 32'd0);
    chk("R8 byte after clear", {23'd0, rxNinth, rxByte}, 32'h0000_0111);
    autoClear = 1'b1;
    idle(10);

    // R9: stop bit cut after its centre, next frame follows at once
    expectFrame(8'h66, 1'b0, "R9 short stop");
    sendFrame(8'h66, 1'b0, 1'b1, 48, 0, -1, 0, 0, -1);
    expectFrame(8'h99, 1'b1, "R9 back-to-back");
    sendFrame(8'h99, 1'b1, 1'b1, 64, -1, -1, 0, 0, -1);
    idle(20);

    // R1: disabled for a whole frame
    rxEnable = 1'b0;
    sendFrame(8'h77, 1'b0, 1'b1, 64, 0, -1, 0, 0, -1);
    idle(20);
    chk("R1 disabled no flag", {31'd0, rxDone}, 32'd0);
    chk("R1 disabled byte kept", {23'd0, rxNinth, rxByte}, 32'h0000_0199);
    // R1: enable drops partway through a frame
    rxEnable = 1'b1;
    idle(20);
    sendFrame(8'h55, 1'b0, 1'b1, 64, 0, -1, 0, 0, 5);
    idle(20);
    chk("R1 drop no flag", {31'd0, rxDone}, 32'd0);
    chk("R1 drop byte kept", {23'd0, rxNinth, rxByte}, 32'h0000_0199);
    rxEnable = 1'b1;
    idle(20);
    expectFrame(8'hE7, 1'b0, "R1 re-enabled frame");
    sendFrame(8'hE7, 1'b0, 1'b1, 64, 2, -1, 0, 0, -1);
    idle(20);

    chk("R5 scoreboard drained", expQ.size(), 32'd0);
    finishRun();
  end

endmodule